// File: doc/BRIEF.md
# Set/Clear/Toggle Aliased Control Register Bank

This block is a bank of 32-bit control registers for a clock and analog control region, reached through a plain word-wide read/write port. Every register owns a group of four consecutive word addresses. The first word of the group is the register itself. The other three are write aliases that change the register bitwise, so software can change one field without a read-modify-write sequence:

| Word in group | Effect of a write |
|---|---|
| +1 | sets bits (OR) |
| +2 | clears bits (AND with the inverted data) |
| +3 | flips bits (XOR) |

Reads through any of the four words return the one stored value.

A small set of registers is marked as PLL controls by a parameter mask. Their lock status bit comes up as 1 out of reset, on top of the reset value. No real locking behaviour is modelled. After reset, that bit is an ordinary writable bit.

An access that is not a full, aligned word is refused. It raises a one-cycle error pulse and changes nothing. Groups beyond the implemented register count read as zero and ignore writes.

Top module: `ccm_alias_bank`

## Requirements
- R1: A write to byte address `16*n + 4` (alias code 1) ORs `bus_wdata` into register n.
- R2: A write to byte address `16*n + 8` (alias code 2) clears every bit of register n that is 1 in `bus_wdata`.
- R3: A write to byte address `16*n + 12` (alias code 3) inverts every bit of register n that is 1 in `bus_wdata`.
- R4: A write to byte address `16*n` (alias code 0) replaces register n with `bus_wdata`.
- R5: A read at any of the four byte addresses `16*n + 4*k` (k = 0..3) returns register n on `bus_rdata` one clock after the request. `bus_rdata` holds its value when no read is accepted.
- R6: After reset the register values are as follows, and `bus_rdata` and `bus_err` are 0:
  - register 0 (system PLL control) = 0x00013001, with bit 31 set because it is a PLL register;
  - register 1 (fractional divider) = 0x1018101B;
  - every other register = 0, with bit 31 set when its bit in `PLL_MASK` is 1 (default mask 0x0D, so registers 0, 2 and 3);
  - the resulting reset values are register 0 = 0x80013001, registers 2 and 3 = 0x80000000.
- R7: The lock bit (bit 31) is forced only by reset. Once cleared through an alias, it reads back as 0.
- R8: An access with `bus_addr[1:0]` not 0, or with `bus_size` not 2'b10 (word), changes no register and leaves `bus_rdata` unchanged. `bus_err` is 1 for exactly the cycle after such an access and is 0 otherwise.
- R9: A read of a group index at or beyond `NUM_REGS` returns 0. A write there changes no register.
- R10: A read and a write to the same register in one cycle return the value held before the write. The write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after a refused access |

## Verification
Every implemented register is driven through all four group words with several overlapping data patterns. A base write lays down a known value, and the set, clear and toggle patterns then share some bits with it and differ in others. Because of this overlap, an OR, AND-NOT and XOR each leave a different result, which exposes a swapped alias. After every write, all four words of the group are read back, so a read path that decodes the alias bits as separate storage is caught. Misaligned offsets, byte and half sizes, the unmapped upper groups and a same-cycle read-and-write are each tried against an arithmetic model, and every register is checked afterwards for disturbance.

// File: rtl/ccm_bank_pkg.sv
package ccm_bank_pkg;

  localparam int DATA_W   = 32;
  localparam int LOCK_BIT = 31;
  localparam logic [1:0] SIZE_WORD = 2'b10;

  typedef enum logic [1:0] {
    OP_BASE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TOG  = 2'd3
  } alias_op_e;

  // Reset value of register idx, with the lock bit forced for PLL registers.
  function automatic logic [DATA_W-1:0] base_reset(input int idx, input bit is_pll);
    logic [DATA_W-1:0] v;
    case (idx)
      0:       v = 32'h0001_3001;
      1:       v = 32'h1018_101B;
      default: v = '0;
    endcase
    if (is_pll) v[LOCK_BIT] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/ccm_alias_decode.sv
module ccm_alias_decode
  import ccm_bank_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = ADDR_W - 4
) (
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              bad,
  output logic              mapped,
  output logic [IDX_W-1:0]  idx,
  output alias_op_e         op
);
  localparam logic [IDX_W:0] NUM_L = (IDX_W+1)'(NUM_REGS);

  always_comb begin
    bad    = (rd | wr) && ((addr[1:0] != 2'b00) || (size != SIZE_WORD));
    idx    = addr[ADDR_W-1:4];
    op     = alias_op_e'(addr[3:2]);
    mapped = ({1'b0, idx} < NUM_L);
  end
endmodule

// File: rtl/ccm_alias_reg.sv
module ccm_alias_reg
  import ccm_bank_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  alias_op_e         op,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] val
);
  always_ff @(posedge clk) begin
    if (rst) begin
      val <= RESET_VAL;
    end else if (we) begin
      unique case (op)
        OP_BASE: val <= wdata;
        OP_SET:  val <= val | wdata;
        OP_CLR:  val <= val & ~wdata;
        OP_TOG:  val <= val ^ wdata;
      endcase
    end
  end

  assert_set_or_R1: assert property (@(posedge clk) disable iff (rst)
    (we && op == OP_SET) |=> val == ($past(val) | $past(wdata)));
  assert_clr_andnot_R2: assert property (@(posedge clk) disable iff (rst)
    (we && op == OP_CLR) |=> val == ($past(val) & ~$past(wdata)));
  assert_tog_xor_R3: assert property (@(posedge clk) disable iff (rst)
    (we && op == OP_TOG) |=> val == ($past(val) ^ $past(wdata)));
  assert_base_write_R4: assert property (@(posedge clk) disable iff (rst)
    (we && op == OP_BASE) |=> val == $past(wdata));
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(val));
endmodule

// File: rtl/ccm_alias_bank.sv
module ccm_alias_bank
  import ccm_bank_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 8,
  parameter logic [NUM_REGS-1:0] PLL_MASK = 8'h0D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err
);
  localparam int IDX_W = ADDR_W - 4;
  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic             bad, mapped;
  logic [IDX_W-1:0] idx;
  alias_op_e        op;
  logic [DATA_W-1:0] vals [NUM_REGS];
  logic [SEL_W-1:0]  sel;
  logic              wr_ok, rd_ok;

  ccm_alias_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .rd(bus_rd), .wr(bus_wr), .addr(bus_addr), .size(bus_size),
    .bad(bad), .mapped(mapped), .idx(idx), .op(op)
  );

  assign sel   = idx[SEL_W-1:0];
  assign wr_ok = bus_wr && !bad && mapped;
  assign rd_ok = bus_rd && !bad;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    ccm_alias_reg #(.RESET_VAL(base_reset(i, PLL_MASK[i]))) u_reg (
      .clk(clk), .rst(rst),
      .we(wr_ok && (sel == SEL_W'(i))),
      .op(op), .wdata(bus_wdata), .val(vals[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= bad;
      if (rd_ok) bus_rdata <= mapped ? vals[sel] : '0;
    end
  end

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bad && !mapped) |=> bus_rdata == '0);
  assert_err_follows_access_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_err) |-> $past(bus_rd || bus_wr));
  assert_bad_holds_rdata_R8: assert property (@(posedge clk) disable iff (rst)
    (bad && !(bus_rd && !bad)) |=> $stable(bus_rdata));
endmodule

// File: tb/ccm_alias_bank_test.sv
module ccm_alias_bank_test;
  localparam int NR = 8;
  localparam logic [7:0] PMASK = 8'h0D;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'b10;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;

  int tests = 0;
  int fails = 0;
  logic [31:0] model [NR];

  always #2.5 clk = ~clk;

  ccm_alias_bank uut (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  // One bus cycle; on return the registered outputs reflect it.
  task automatic bus(input bit rd, input bit wr, input logic [7:0] a,
                     input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr_alias(input int r, input int k, input logic [31:0] d);
    bus(1'b0, 1'b1, 8'(16*r + 4*k), 2'b10, d);
    case (k)
      0: model[r] = d;
      1: model[r] = model[r] | d;
      2: model[r] = model[r] & ~d;
      default: model[r] = model[r] ^ d;
    endcase
  endtask

  task automatic read_group(input int r, input string req);
    for (int k = 0; k < 4; k++) begin
      bus(1'b1, 1'b0, 8'(16*r + 4*k), 2'b10, 32'h0);
      chk(req, bus_rdata, model[r]);
    end
  endtask

  task automatic check_all(input string req);
    for (int r = 0; r < NR; r++) begin
      bus(1'b1, 1'b0, 8'(16*r), 2'b10, 32'h0);
      chk(req, bus_rdata, model[r]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R6 rdata after reset", bus_rdata, 32'h0);
    chk("R6 err after reset", {31'h0, bus_err}, 32'h0);
    for (int r = 0; r < NR; r++) begin
      model[r] = (r == 0) ? 32'h0001_3001 : (r == 1) ? 32'h1018_101B : 32'h0;
      if (PMASK[r]) model[r] = model[r] + 32'h8000_0000;
    end
    check_all("R6 reset value");

    // R7: lock bit cleared stays cleared
    wr_alias(0, 2, 32'h8000_0000);
    read_group(0, "R7 lock cleared");
    chk("R7 lock value", model[0], 32'h0001_3001);

    // Sweep: every register, every alias, several patterns (R1..R5)
    for (int p = 0; p < 3; p++) begin
      for (int r = 0; r < NR; r++) begin
        logic [31:0] b;
        b = 32'hC3A5_5A3C ^ (32'(r) * 32'h1111_1111) ^ (32'(p) * 32'h0F0F_3C3C);
        wr_alias(r, 0, b);               read_group(r, "R4/R5 base write");
        wr_alias(r, 1, b ^ 32'h00FF_F00F); read_group(r, "R1 set alias");
        wr_alias(r, 2, b ^ 32'h0FF0_0FF0); read_group(r, "R2 clear alias");
        wr_alias(r, 3, 32'hF0F0_6699 ^ b); read_group(r, "R3 toggle alias");
      end
    end

    // R8: refused accesses
    prev = bus_rdata;
    bus(1'b0, 1'b1, 8'h11, 2'b10, 32'hDEAD_BEEF);
    chk("R8 err after misaligned write", {31'h0, bus_err}, 32'h1);
    bus(1'b0, 1'b0, 8'h00, 2'b10, 32'h0);
    chk("R8 err is one cycle", {31'h0, bus_err}, 32'h0);
    bus(1'b0, 1'b1, 8'h20, 2'b00, 32'hFFFF_FFFF);
    chk("R8 err after byte write", {31'h0, bus_err}, 32'h1);
    bus(1'b0, 1'b1, 8'h34, 2'b01, 32'hFFFF_FFFF);
    chk("R8 err after half write", {31'h0, bus_err}, 32'h1);
    bus(1'b1, 1'b0, 8'h02, 2'b10, 32'h0);
    chk("R8 err after misaligned read", {31'h0, bus_err}, 32'h1);
    chk("R8 rdata held", bus_rdata, prev);
    check_all("R8 no register changed");

    // R9: unmapped groups
    for (int g = NR; g < 16; g++) begin
      bus(1'b1, 1'b0, 8'(16*g + 4*(g % 4)), 2'b10, 32'h0);
      chk("R9 unmapped read zero", bus_rdata, 32'h0);
      chk("R9 no error", {31'h0, bus_err}, 32'h0);
      bus(1'b0, 1'b1, 8'(16*g), 2'b10, 32'h1234_5678);
    end
    check_all("R9 unmapped write ignored");

    // R10: read and write in one cycle
    prev = model[2];
    bus(1'b1, 1'b1, 8'h20, 2'b10, 32'h5555_AAAA);
    chk("R10 old value returned", bus_rdata, prev);
    model[2] = 32'h5555_AAAA;
    prev = model[5];
    bus(1'b1, 1'b1, 8'h5C, 2'b10, 32'h0000_FFFF);
    chk("R10 old value via toggle", bus_rdata, prev);
    model[5] = model[5] ^ 32'h0000_FFFF;
    check_all("R10 write took effect");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule